// File: doc/BRIEF.md
# Serial Configuration Host Loader

This block is the host side of a serial configuration link. When `start` is pulsed it resets the target device with a low strobe on `tgt_rst_n`. It then waits until the target signals ready on `tgt_ready_n`, and streams bytes taken from a valid/ready byte source onto `tgt_data`, most significant bit first. Each bit is framed by a serial clock `tgt_clk` that the block generates.

The target samples data on the rising edge of `tgt_clk`, so the loader changes `tgt_data` only while the clock is low. The serial clock comes from the system clock through a divider: `half_per` system cycles per phase, with a minimum of one cycle. After the byte marked last, the loader keeps clocking with the data line held high. This supplies the extra cycles the target needs to finish its start-up. The attempt ends when the target raises `tgt_done`, which is success. It also ends if the target pulls its ready line low at any point in the transfer, or if one of the timeouts runs out. Both of those are errors.

Status goes to local logic on `busy`, `cfg_ok` and `cfg_err`. Both target inputs pass through two-stage synchronizers before the loader acts on them.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset `tgt_rst_n`=1, `tgt_clk`=0, `busy`=0, `cfg_ok`=0, `cfg_err`=0 and `byte_ready`=0. `tgt_mode` reads 3'b111 at all times.
- R2: A `start` pulse seen while idle, succeeded or failed drives `tgt_rst_n` low for exactly PROG_LEN system cycles. `tgt_clk` stays low throughout the pulse.
- R3: After the pulse no `tgt_clk` edge occurs until the synchronized `tgt_ready_n` is high. If it stays low for INIT_TMO cycles after the pulse ends, `cfg_err` is raised and no clock is ever issued.
- R4: `tgt_data` is stable while `tgt_clk` is high. Every high phase of `tgt_clk` lasts max(`half_per`,1) system cycles.
- R5: Bits go out MSB first, one per rising edge. A byte is accepted (`byte_ready`=1 with `byte_valid`=1) only once all 8 bits of the previous byte have been clocked, that is after exactly 8*k rising edges for the k-th byte counted from 0. `byte_ready` is high only while `tgt_clk` is low.
- R6: If the synchronized `tgt_ready_n` is low during shifting or trailing clocks, the loader moves to error on the next cycle, and `tgt_clk` stops low with no further edges.
- R7: After the last byte, `tgt_clk` keeps toggling with `tgt_data`=1. If `tgt_done` has not risen by TRAIL_MAX trailing clocks, the loader ends in error after exactly TRAIL_MAX extra rising edges.
- R8: `tgt_done` seen high during shifting or trailing clocks ends the attempt with `cfg_ok`=1.
- R9: `start` is ignored while `busy` is high. The running attempt completes with no second reset pulse.
- R10: `busy`, `cfg_ok` and `cfg_err` are never high together. In error, `tgt_clk` is low and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a configuration attempt |
| half_per | input | DIV_W | System cycles per serial clock phase (0 treated as 1) |
| byte_data | input | 8 | Byte from the source |
| byte_valid | input | 1 | Source has a byte |
| byte_last | input | 1 | Current byte is the final one |
| byte_ready | output | 1 | Loader takes the byte this cycle if valid |
| tgt_rst_n | output | 1 | Program-reset strobe to the target, active low |
| tgt_clk | output | 1 | Serial clock to the target |
| tgt_data | output | 1 | Serial data to the target |
| tgt_mode | output | 3 | Fixed mode select, 3'b111 |
| tgt_ready_n | input | 1 | Target init/status line: high is ready, low is error |
| tgt_done | input | 1 | Target completion line |
| busy | output | 1 | Attempt in progress |
| cfg_ok | output | 1 | Last attempt succeeded |
| cfg_err | output | 1 | Last attempt failed |

## Verification
Several properties are checked on every cycle: the clock stays silent during the reset pulse, data holds while the clock is high, `byte_ready` appears only in the low phase, a ready-line drop mid-transfer leads to error on the next cycle, and the three status flags stay mutually exclusive with a quiet clock in error. Other behaviours are shown only by the bench scenarios. These are the bit order of the stream, the exact high-phase length across a sweep of divider values, the exact reset pulse and timeout lengths, the count of trailing clocks before a trailing timeout, and the point at which each byte is taken. They span whole attempts and need a model of the target to judge.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PULSE, ST_WAIT, ST_SHIFT, ST_TRAIL, ST_OK, ST_ERR
  } scl_state_e;

  function automatic int scl_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // next shift-register content after one MSB-first bit leaves
  function automatic logic [7:0] scl_next_bits(input logic [7:0] b);
    return {b[6:0], 1'b0};
  endfunction
endpackage

// File: rtl/scl_sync2.sv
module scl_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/scl_cclk_gen.sv
module scl_cclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] half_per,
  output logic             clk_raw,
  output logic             rise_evt,
  output logic             fall_evt
);
  // last count value of one phase; a zero setting behaves as one
  function automatic logic [DIV_W-1:0] phase_last(input logic [DIV_W-1:0] h);
    return (h == '0) ? '0 : h - 1'b1;
  endfunction

  logic [DIV_W-1:0] pcnt;
  logic             wrap;

  assign wrap     = run && !restart && (pcnt >= phase_last(half_per));
  assign rise_evt = wrap && !clk_raw;
  assign fall_evt = wrap && clk_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt    <= '0;
      clk_raw <= 1'b0;
    end else if (!run || restart) begin
      pcnt    <= '0;
      clk_raw <= 1'b0;
    end else if (wrap) begin
      pcnt    <= '0;
      clk_raw <= ~clk_raw;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import scl_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int PROG_LEN  = 16,
  parameter int INIT_TMO  = 4096,
  parameter int TRAIL_MAX = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] half_per,
  input  logic [7:0]       byte_data,
  input  logic             byte_valid,
  input  logic             byte_last,
  output logic             byte_ready,
  output logic             tgt_rst_n,
  output logic             tgt_clk,
  output logic             tgt_data,
  output logic [2:0]       tgt_mode,
  input  logic             tgt_ready_n,
  input  logic             tgt_done,
  output logic             busy,
  output logic             cfg_ok,
  output logic             cfg_err
);
  localparam int CNT_W = $clog2(scl_max(scl_max(PROG_LEN, INIT_TMO), TRAIL_MAX) + 1);

  scl_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       sh;
  logic [2:0]       bitcnt;
  logic             have;
  logic             last_q;
  logic             init_s;
  logic             done_s;
  logic             clk_raw;
  logic             rise_evt;
  logic             fall_evt;
  logic             load_evt;
  logic             xfer_active;
  logic             run;
  logic             can_start;

  scl_sync2 u_sync_init (.clk(clk), .rst_n(rst_n), .d(tgt_ready_n), .q(init_s));
  scl_sync2 u_sync_done (.clk(clk), .rst_n(rst_n), .d(tgt_done),    .q(done_s));

  assign xfer_active = (state == ST_SHIFT) || (state == ST_TRAIL);
  assign run         = xfer_active && (have || (state == ST_TRAIL));
  assign byte_ready  = (state == ST_SHIFT) && !have;
  assign load_evt    = byte_ready && byte_valid;
  assign can_start   = (state == ST_IDLE) || (state == ST_OK) || (state == ST_ERR);

  scl_cclk_gen #(.DIV_W(DIV_W)) u_cclk (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(load_evt),
    .half_per(half_per), .clk_raw(clk_raw), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      bitcnt <= '0;
      have   <= 1'b0;
      last_q <= 1'b0;
    end else begin
      case (state)
        ST_PULSE: begin
          if (cnt == '0) begin
            state <= ST_WAIT;
            cnt   <= CNT_W'(INIT_TMO - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WAIT: begin
          if (init_s)            state <= ST_SHIFT;
          else if (cnt == '0)    state <= ST_ERR;
          else                   cnt   <= cnt - 1'b1;
        end
        ST_SHIFT: begin
          if (!init_s) begin
            state <= ST_ERR;
            have  <= 1'b0;
          end else if (done_s) begin
            state <= ST_OK;
            have  <= 1'b0;
          end else if (load_evt) begin
            sh     <= byte_data;
            last_q <= byte_last;
            bitcnt <= '0;
            have   <= 1'b1;
          end else if (fall_evt) begin
            if (bitcnt == 3'd7) begin
              have <= 1'b0;
              if (last_q) begin
                state <= ST_TRAIL;
                cnt   <= '0;
              end
            end else begin
              sh     <= scl_next_bits(sh);
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_TRAIL: begin
          if (!init_s)           state <= ST_ERR;
          else if (done_s)       state <= ST_OK;
          else if (fall_evt) begin
            if (cnt == CNT_W'(TRAIL_MAX - 1)) state <= ST_ERR;
            else                              cnt   <= cnt + 1'b1;
          end
        end
        default: begin
          if (can_start && start) begin
            state <= ST_PULSE;
            cnt   <= CNT_W'(PROG_LEN - 1);
            have  <= 1'b0;
            sh    <= '0;
          end
        end
      endcase
    end
  end

  assign tgt_rst_n = (state != ST_PULSE);
  assign tgt_clk   = clk_raw && xfer_active;
  assign tgt_data  = (state == ST_TRAIL) ? 1'b1 : sh[7];
  assign tgt_mode  = 3'b111;
  assign busy      = (state == ST_PULSE) || (state == ST_WAIT) || xfer_active;
  assign cfg_ok    = (state == ST_OK);
  assign cfg_err   = (state == ST_ERR);

  logic unused_rise;
  assign unused_rise = rise_evt;
endmodule

// File: rtl/scl_checker.sv
module scl_checker (
  input logic clk,
  input logic rst_n,
  input logic tgt_rst_n,
  input logic tgt_clk,
  input logic tgt_data,
  input logic busy,
  input logic cfg_ok,
  input logic cfg_err,
  input logic byte_ready,
  input logic xfer_active,
  input logic init_s
);
  AST_RST_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_rst_n |-> !tgt_clk); // R2

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_clk && $past(tgt_clk)) |-> $stable(tgt_data)); // R4

  AST_READY_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> !tgt_clk); // R5

  AST_INIT_DROP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && !init_s) |=> cfg_err); // R6

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!tgt_clk && !busy)); // R10

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({busy, cfg_ok, cfg_err}) <= 1); // R10
endmodule

bind serial_cfg_loader scl_checker u_scl_chk (
  .clk(clk), .rst_n(rst_n), .tgt_rst_n(tgt_rst_n), .tgt_clk(tgt_clk),
  .tgt_data(tgt_data), .busy(busy), .cfg_ok(cfg_ok), .cfg_err(cfg_err),
  .byte_ready(byte_ready), .xfer_active(xfer_active), .init_s(init_s)
);

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb_top;
  localparam int PL  = 16;
  localparam int TMO = 100;
  localparam int TM  = 64;
  localparam int INIT_DLY = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] half_per = 8'd1;
  logic [7:0] byte_data;
  logic       byte_valid, byte_last, byte_ready;
  logic       tgt_rst_n, tgt_clk, tgt_data;
  logic [2:0] tgt_mode;
  logic       tgt_ready_n = 1'b0;
  logic       tgt_done = 1'b0;
  logic       busy, cfg_ok, cfg_err;

  serial_cfg_loader #(.DIV_W(8), .PROG_LEN(PL), .INIT_TMO(TMO), .TRAIL_MAX(TM)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .half_per(half_per),
    .byte_data(byte_data), .byte_valid(byte_valid), .byte_last(byte_last),
    .byte_ready(byte_ready), .tgt_rst_n(tgt_rst_n), .tgt_clk(tgt_clk),
    .tgt_data(tgt_data), .tgt_mode(tgt_mode), .tgt_ready_n(tgt_ready_n),
    .tgt_done(tgt_done), .busy(busy), .cfg_ok(cfg_ok), .cfg_err(cfg_err)
  );

  int checks = 0;
  int errors = 0;

  // byte source and target model state
  logic [7:0] mem [0:7];
  int  nbytes = 0, idx = 0;
  bit  src_on = 0, pend = 0;
  bit  init_en = 1;
  int  done_at = 0, drop_at = 0;
  int  since_prog = 0;
  // monitor state
  logic bits [0:127];
  int  rises = 0, phase_len = 0, hi_err = 0, acc_err = 0;
  int  prog_low = 0, busy_hi = 0, eh = 1;
  logic prev_clk = 1'b0;

  assign byte_valid = src_on && (idx < nbytes);
  assign byte_data  = mem[idx[2:0]];
  assign byte_last  = (idx == nbytes - 1);

  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) begin idx++; pend = 0; end
      if (byte_valid && byte_ready) begin
        if (rises != 8 * idx) acc_err++;
        pend = 1;
      end
      if (!tgt_rst_n) begin
        prog_low++; tgt_ready_n = 1'b0; tgt_done = 1'b0; since_prog = 0;
      end else begin
        since_prog++;
        if (busy) busy_hi++;
        if (init_en && since_prog == INIT_DLY) tgt_ready_n = 1'b1;
      end
      if (tgt_clk && !prev_clk) begin
        if (rises < 128) bits[rises] = tgt_data;
        rises++;
        if (done_at != 0 && rises == done_at) tgt_done = 1'b1;
        if (drop_at != 0 && rises == drop_at) tgt_ready_n = 1'b0;
      end
      if (tgt_clk != prev_clk) begin
        if (prev_clk && !cfg_ok && !cfg_err && phase_len != eh) hi_err++;
        phase_len = 1;
      end else begin
        phase_len++;
      end
      prev_clk = tgt_clk;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run(input int h, input int nb, input int d_at, input int dr_at,
                     input bit ini, input int poke);
    int n;
    bit poked;
    @(negedge clk); #1;
    half_per = 8'(h);
    eh = (h == 0) ? 1 : h;
    nbytes = nb;
    for (int i = 0; i < 8; i++) mem[i] = 8'((8'hA5 ^ (i * 37) ^ (h * 16 + nb)) & 8'hFF);
    idx = 0; pend = 0; src_on = 1;
    done_at = d_at; drop_at = dr_at; init_en = ini;
    rises = 0; hi_err = 0; acc_err = 0; prog_low = 0; busy_hi = 0;
    for (int i = 0; i < 128; i++) bits[i] = 1'bx;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    n = 0; poked = 0;
    while (!(cfg_ok || cfg_err) && n < 30000) begin
      @(negedge clk); #1;
      n++;
      if (poke != 0 && !poked && rises >= poke) begin start = 1'b1; poked = 1; end
      else start = 1'b0;
    end
    start = 1'b0;
  endtask

  task automatic check_bits(input int nb, input string req);
    int bad;
    for (int b = 0; b < nb; b++) begin
      bad = 0;
      for (int k = 0; k < 8; k++)
        if (bits[b*8+k] !== mem[b][7-k]) bad++;
      chk(bad == 0, req, "byte bits mismatched", bad, 0);
    end
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(tgt_rst_n === 1'b1, "R1", "rst strobe idle", int'(tgt_rst_n), 1);
    chk(tgt_clk === 1'b0 && busy === 1'b0, "R1", "clk/busy idle", int'({tgt_clk, busy}), 0);
    chk(cfg_ok === 1'b0 && cfg_err === 1'b0 && byte_ready === 1'b0, "R1",
        "status idle", int'({cfg_ok, cfg_err, byte_ready}), 0);
    chk(tgt_mode === 3'b111, "R1", "mode pins", int'(tgt_mode), 7);

    // sweep divider and byte count: R2 R3 R4 R5 R7 R8
    for (int h = 0; h < 4; h++) begin
      for (int nb = 1; nb < 4; nb++) begin
        int dat;
        dat = 8 * nb + ((h + nb) % 5) + 1;
        run(h, nb, dat, 0, 1, 0);
        chk(cfg_ok === 1'b1, "R8", "success flag", int'(cfg_ok), 1);
        chk(prog_low == PL, "R2", "reset pulse length", prog_low, PL);
        check_bits(nb, "R5");
        chk(acc_err == 0, "R5", "byte taken off boundary", acc_err, 0);
        chk(hi_err == 0, "R4", "high phase length", hi_err, 0);
        begin
          int bad1;
          bad1 = 0;
          for (int b = 8 * nb; b < dat; b++) if (bits[b] !== 1'b1) bad1++;
          chk(bad1 == 0, "R7", "trailing data not 1", bad1, 0);
        end
        chk(rises >= dat && rises <= dat + 3, "R8", "edges before done", rises, dat);
        chk(tgt_mode === 3'b111, "R1", "mode pins mid run", int'(tgt_mode), 7);
      end
    end

    // R3 timeout: target never ready
    run(2, 2, 0, 0, 0, 0);
    chk(cfg_err === 1'b1, "R3", "timeout error", int'(cfg_err), 1);
    chk(busy_hi == TMO, "R3", "wait window length", busy_hi, TMO);
    chk(rises == 0, "R3", "no clock before ready", rises, 0);

    // R6 ready line drops mid stream
    run(2, 3, 0, 10, 1, 0);
    chk(cfg_err === 1'b1, "R6", "drop gives error", int'(cfg_err), 1);
    chk(rises <= 11, "R6", "edges after drop", rises, 11);
    begin
      int r0;
      r0 = rises;
      repeat (20) @(negedge clk);
      #1;
      chk(rises == r0 && tgt_clk === 1'b0, "R6", "clock stopped", rises, r0);
      chk(busy === 1'b0 && tgt_clk === 1'b0, "R10", "quiet in error", int'({busy, tgt_clk}), 0);
    end

    // R7 trailing timeout: done never rises
    run(1, 2, 0, 0, 1, 0);
    chk(cfg_err === 1'b1, "R7", "trailing timeout error", int'(cfg_err), 1);
    chk(rises == 16 + TM, "R7", "trailing edge count", rises, 16 + TM);
    check_bits(2, "R7");

    // R9 start while busy ignored
    run(2, 3, 27, 0, 1, 12);
    chk(cfg_ok === 1'b1, "R9", "attempt completes", int'(cfg_ok), 1);
    chk(prog_low == PL, "R9", "no second reset pulse", prog_low, PL);
    check_bits(3, "R9");

    // restart from error then succeed
    run(3, 1, 0, 0, 0, 0);
    run(1, 1, 9, 0, 1, 0);
    chk(cfg_ok === 1'b1 && cfg_err === 1'b0, "R10", "restart after error",
        int'({cfg_ok, cfg_err}), 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule